// File: doc/BRIEF.md
# Single-Channel DMA Sequencer with Abort Handling

This block moves data for one DMA channel. It issues one read at the current source address, then writes the returned word to the current destination address. Each such read-then-write pair is one sequence. A minor loop is a fixed number of sequences, and the major loop repeats the minor loop a programmed number of times. After each successful beat, the source and destination addresses move by signed offsets. The iteration count drops by one at the end of each minor loop. The working addresses and the count are visible as descriptor outputs, so the channel's state can be read after it stops.

A job stops early in three ways: a bus error reported with a read or write response, a software cancel, or an error cancel. Because the engine has a two-phase pipeline, a bus error does not stop the channel at once. The opposite-side access that is already due is still carried out, and then the channel stops. A cancel waits for the current sequence to finish. A cancel that arrives during the last sequence of a minor loop is dropped. The error status register records bus errors and error cancels. It keeps them until a write-one clear strobe, and it drives an error interrupt when interrupts are enabled.

Top module: `dma_seq_abort`

## Requirements
- R1: After reset, `busy`, `rd_req`, `wr_req`, `done`, every error status flag and `err_irq` are 0.
- R2: Each sequence reads at `cur_src` and then writes the returned read data to `cur_dst`. A successful read adds the signed source offset to the source address. A successful write adds the signed destination offset to the destination address. The iteration count drops by one after every `cfg_nbeats` successful sequences. The offsets are two's complement, `OW` bits wide.
- R3: When the final sequence of the last minor loop completes, `done` is high for exactly one cycle, `busy` falls, and `cur_iter` reads 0.
- R4: `rd_req` and `wr_req` are never high together. Each request, and its address and write data, holds steady until its response arrives.
- R5: A read that returns with an error sets `es_sbe` and `es_vld` and loads `CH_ID` into `es_chn`. The write of that sequence still goes to the unadvanced `cur_dst`, carrying the data returned with the error. Then the channel stops without `done`. `cur_src` keeps the faulting address, and `cur_iter` is not decremented.
- R6: A write that returns with an error on any sequence except the job's final one sets `es_dbe` and `es_vld`. The next read, at the already advanced source address, is still issued. Then the channel stops without any further write. `cur_dst` keeps the faulting address, and `cur_iter` is not decremented.
- R7: A write error on the final sequence of the job stops the channel at once, with no further read, and `done` stays low.
- R8: A cancel that arrives while a sequence that is not the last of its minor loop is in flight lets that sequence finish and then stops the channel without `done`. The descriptor holds the addresses advanced by that sequence. A plain cancel leaves the error status untouched.
- R9: A cancel or error cancel that arrives during the last sequence of a minor loop is discarded. The job continues and retires normally, and the error status is not changed.
- R10: An error cancel that is honoured stops the channel as in R8. It also sets `es_ecx` and `es_vld` and loads `CH_ID` into `es_chn`.
- R11: `err_irq` is high exactly while `es_vld` is set and `err_irq_en` is high.
- R12: The error status flags hold their values until an `es_clr` pulse. The pulse clears all of them. If a new event and `es_clr` occur in the same cycle, the event wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Load descriptor and begin a job (ignored while busy) |
| cfg_src | input | AW | Initial source address |
| cfg_dst | input | AW | Initial destination address |
| cfg_soff | input | OW | Signed source offset per beat |
| cfg_doff | input | OW | Signed destination offset per beat |
| cfg_nbeats | input | BW | Sequences per minor loop (at least 1) |
| cfg_iter | input | IW | Minor loop count (at least 1) |
| cancel | input | 1 | Software cancel pulse |
| err_cancel | input | 1 | Error cancel pulse |
| rd_req | output | 1 | Read request, held until response |
| rd_addr | output | AW | Read address |
| rd_rsp | input | 1 | Read response strobe |
| rd_data | input | DW | Read data |
| rd_err | input | 1 | Read response carries a bus error |
| wr_req | output | 1 | Write request, held until response |
| wr_addr | output | AW | Write address |
| wr_data | output | DW | Write data |
| wr_rsp | input | 1 | Write response strobe |
| wr_err | input | 1 | Write response carries a bus error |
| busy | output | 1 | Job in progress |
| done | output | 1 | One-cycle pulse on normal retirement |
| cur_src | output | AW | Descriptor source address |
| cur_dst | output | AW | Descriptor destination address |
| cur_iter | output | IW | Descriptor iteration count |
| err_irq_en | input | 1 | Error interrupt enable |
| es_clr | input | 1 | Write-one clear of the error status |
| es_chn | output | CHW | Channel number of the recorded error |
| es_sbe | output | 1 | Source bus error flag |
| es_dbe | output | 1 | Destination bus error flag |
| es_ecx | output | 1 | Error cancel flag |
| es_vld | output | 1 | Error status valid |
| err_irq | output | 1 | Error interrupt request |

## Verification
The bench targets the pipeline edges of the abort logic. It puts read errors on the last read of a job and checks that the write still carries the error-time data to the unadvanced destination; a design that stopped at once would skip that write. It puts write errors on the last beat of a minor loop, where a wrong design would drop the trailing read or decrement the count. It also puts write errors on the final sequence, where a spurious extra read would appear. Cancels and error cancels are placed on both last and non-last sequences of a minor loop. A design that ignored the position rule would either stop a job that should retire, with no `done`, or set the error-cancel flag on a discarded request.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RD   = 2'd1,
      ST_WR   = 2'd2
   } seq_st_e;

   typedef struct packed {
      logic vld;
      logic ecx;
      logic sbe;
      logic dbe;
   } es_flags_t;

endpackage

// File: rtl/dma_seq_desc.sv
module dma_seq_desc #(
   parameter int AW = 32,
   parameter int OW = 16,
   parameter int IW = 16,
   parameter int BW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [AW-1:0] ld_src,
   input  logic [AW-1:0] ld_dst,
   input  logic [OW-1:0] ld_soff,
   input  logic [OW-1:0] ld_doff,
   input  logic [BW-1:0] ld_nbeats,
   input  logic [IW-1:0] ld_iter,
   input  logic          adv_src,
   input  logic          step,
   output logic [AW-1:0] src,
   output logic [AW-1:0] dst,
   output logic [IW-1:0] iter,
   output logic          beat_last,
   output logic          iter_last
);

   logic [AW-1:0] src_q, dst_q;
   logic [OW-1:0] soff_q, doff_q;
   logic [BW-1:0] nb_q, beat_q;
   logic [IW-1:0] iter_q;
   logic [AW-1:0] soff_x, doff_x;

   generate
      if (OW < AW) begin : g_sext
         assign soff_x = {{(AW-OW){soff_q[OW-1]}}, soff_q};
         assign doff_x = {{(AW-OW){doff_q[OW-1]}}, doff_q};
      end else begin : g_full
         assign soff_x = soff_q;
         assign doff_x = doff_q;
      end
   endgenerate

   assign beat_last = ((beat_q + BW'(1)) == nb_q);
   assign iter_last = (iter_q == IW'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         src_q  <= '0;
         dst_q  <= '0;
         soff_q <= '0;
         doff_q <= '0;
         nb_q   <= '0;
         beat_q <= '0;
         iter_q <= '0;
      end else if (load) begin
         src_q  <= ld_src;
         dst_q  <= ld_dst;
         soff_q <= ld_soff;
         doff_q <= ld_doff;
         nb_q   <= ld_nbeats;
         beat_q <= '0;
         iter_q <= ld_iter;
      end else begin
         if (adv_src) src_q <= src_q + soff_x;
         if (step) begin
            dst_q <= dst_q + doff_x;
            if (beat_last) begin
               beat_q <= '0;
               iter_q <= iter_q - IW'(1);
            end else begin
               beat_q <= beat_q + BW'(1);
            end
         end
      end
   end

   assign src  = src_q;
   assign dst  = dst_q;
   assign iter = iter_q;

endmodule

// File: rtl/dma_seq_errstat.sv
module dma_seq_errstat
   import dma_seq_pkg::*;
#(
   parameter int CHW   = 4,
   parameter int CH_ID = 5
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           set_sbe,
   input  logic           set_dbe,
   input  logic           set_ecx,
   input  logic           clr,
   input  logic           irq_en,
   output logic [CHW-1:0] chn,
   output es_flags_t      flags,
   output logic           irq
);

   es_flags_t     fl_q;
   logic [CHW-1:0] chn_q;
   logic          any_set;

   assign any_set = set_sbe | set_dbe | set_ecx;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fl_q  <= '0;
         chn_q <= '0;
      end else if (any_set) begin
         fl_q.vld <= 1'b1;
         fl_q.sbe <= fl_q.sbe | set_sbe;
         fl_q.dbe <= fl_q.dbe | set_dbe;
         fl_q.ecx <= fl_q.ecx | set_ecx;
         chn_q    <= CHW'(CH_ID);
      end else if (clr) begin
         fl_q  <= '0;
         chn_q <= '0;
      end
   end

   assign flags = fl_q;
   assign chn   = chn_q;
   assign irq   = fl_q.vld & irq_en;

endmodule

// File: rtl/dma_seq_abort.sv
module dma_seq_abort
   import dma_seq_pkg::*;
#(
   parameter int AW    = 32,
   parameter int DW    = 32,
   parameter int OW    = 16,
   parameter int IW    = 16,
   parameter int BW    = 8,
   parameter int CHW   = 4,
   parameter int CH_ID = 5
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           start,
   input  logic [AW-1:0]  cfg_src,
   input  logic [AW-1:0]  cfg_dst,
   input  logic [OW-1:0]  cfg_soff,
   input  logic [OW-1:0]  cfg_doff,
   input  logic [BW-1:0]  cfg_nbeats,
   input  logic [IW-1:0]  cfg_iter,
   input  logic           cancel,
   input  logic           err_cancel,
   output logic           rd_req,
   output logic [AW-1:0]  rd_addr,
   input  logic           rd_rsp,
   input  logic [DW-1:0]  rd_data,
   input  logic           rd_err,
   output logic           wr_req,
   output logic [AW-1:0]  wr_addr,
   output logic [DW-1:0]  wr_data,
   input  logic           wr_rsp,
   input  logic           wr_err,
   output logic           busy,
   output logic           done,
   output logic [AW-1:0]  cur_src,
   output logic [AW-1:0]  cur_dst,
   output logic [IW-1:0]  cur_iter,
   input  logic           err_irq_en,
   input  logic           es_clr,
   output logic [CHW-1:0] es_chn,
   output logic           es_sbe,
   output logic           es_dbe,
   output logic           es_ecx,
   output logic           es_vld,
   output logic           err_irq
);

   initial begin
      param_ok_chk: assert (OW <= AW && OW > 1 && BW > 0 && IW > 0 && DW > 0
                            && CH_ID >= 0 && CH_ID < (1 << CHW))
         else $error("dma_seq_abort: illegal parameter set");
   end

   seq_st_e        st_q, st_d;
   logic           abort_q, abort_d;
   logic           pend_q, pend_nx;
   logic           ecxp_q, ecxp_nx;
   logic           done_q;
   logic [DW-1:0]  rdat_q;
   logic           beat_last, iter_last, final_seq;
   logic           load, adv_src, step;
   logic           set_sbe, set_dbe, set_ecx, stop_cxl, cxl_now;
   es_flags_t      fl;

   assign busy      = (st_q != ST_IDLE);
   assign load      = (st_q == ST_IDLE) & start;
   assign final_seq = beat_last & iter_last;

   // cancel is judged against the sequence in flight when it arrives
   assign cxl_now = busy & (cancel | err_cancel) & ~beat_last;
   assign pend_nx = pend_q | cxl_now;
   assign ecxp_nx = ecxp_q | (busy & err_cancel & ~beat_last);

   assign adv_src  = (st_q == ST_RD) & rd_rsp & ~rd_err & ~abort_q;
   assign set_sbe  = (st_q == ST_RD) & rd_rsp & rd_err;
   assign set_dbe  = (st_q == ST_WR) & wr_rsp & wr_err;
   assign step     = (st_q == ST_WR) & wr_rsp & ~wr_err & ~abort_q;
   assign stop_cxl = step & ~beat_last & pend_nx;
   assign set_ecx  = stop_cxl & ecxp_nx;

   always_comb begin
      st_d    = st_q;
      abort_d = abort_q;
      unique case (st_q)
         ST_IDLE: if (start) begin
            st_d    = ST_RD;
            abort_d = 1'b0;
         end
         ST_RD: if (rd_rsp) begin
            if (abort_q) begin
               st_d = ST_IDLE;
            end else begin
               st_d = ST_WR;
               if (rd_err) abort_d = 1'b1;
            end
         end
         ST_WR: if (wr_rsp) begin
            if (abort_q) begin
               st_d = ST_IDLE;
            end else if (wr_err) begin
               st_d    = final_seq ? ST_IDLE : ST_RD;
               abort_d = ~final_seq;
            end else if (final_seq || stop_cxl) begin
               st_d = ST_IDLE;
            end else begin
               st_d = ST_RD;
            end
         end
         default: st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         abort_q <= 1'b0;
         pend_q  <= 1'b0;
         ecxp_q  <= 1'b0;
         done_q  <= 1'b0;
         rdat_q  <= '0;
      end else begin
         st_q    <= st_d;
         abort_q <= abort_d;
         done_q  <= step & final_seq;
         if (load) begin
            pend_q <= 1'b0;
            ecxp_q <= 1'b0;
         end else if (step) begin
            pend_q <= 1'b0;
            ecxp_q <= 1'b0;
         end else begin
            pend_q <= pend_nx;
            ecxp_q <= ecxp_nx;
         end
         if ((st_q == ST_RD) && rd_rsp) rdat_q <= rd_data;
      end
   end

   dma_seq_desc #(.AW(AW), .OW(OW), .IW(IW), .BW(BW)) desc_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (load),
      .ld_src    (cfg_src),
      .ld_dst    (cfg_dst),
      .ld_soff   (cfg_soff),
      .ld_doff   (cfg_doff),
      .ld_nbeats (cfg_nbeats),
      .ld_iter   (cfg_iter),
      .adv_src   (adv_src),
      .step      (step),
      .src       (cur_src),
      .dst       (cur_dst),
      .iter      (cur_iter),
      .beat_last (beat_last),
      .iter_last (iter_last)
   );

   dma_seq_errstat #(.CHW(CHW), .CH_ID(CH_ID)) es_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_sbe (set_sbe),
      .set_dbe (set_dbe),
      .set_ecx (set_ecx),
      .clr     (es_clr),
      .irq_en  (err_irq_en),
      .chn     (es_chn),
      .flags   (fl),
      .irq     (err_irq)
   );

   assign es_sbe  = fl.sbe;
   assign es_dbe  = fl.dbe;
   assign es_ecx  = fl.ecx;
   assign es_vld  = fl.vld;

   assign rd_req  = (st_q == ST_RD);
   assign wr_req  = (st_q == ST_WR);
   assign rd_addr = cur_src;
   assign wr_addr = cur_dst;
   assign wr_data = rdat_q;
   assign done    = done_q;

endmodule

// File: rtl/dma_seq_abort_chk.sv
module dma_seq_abort_chk #(
   parameter int AW = 32,
   parameter int DW = 32
) (
   input logic          clk,
   input logic          rst_n,
   input logic          rd_req,
   input logic          rd_rsp,
   input logic [AW-1:0] rd_addr,
   input logic          wr_req,
   input logic          wr_rsp,
   input logic [AW-1:0] wr_addr,
   input logic [DW-1:0] wr_data,
   input logic          busy,
   input logic          done,
   input logic          es_vld,
   input logic          es_ecx,
   input logic          es_sbe,
   input logic          es_dbe,
   input logic          es_clr,
   input logic          err_irq
);

   // R4
   one_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(rd_req && wr_req));

   // R4
   rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && !rd_rsp) |=> (rd_req && $stable(rd_addr)));

   // R4
   wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_req && !wr_rsp) |=> (wr_req && $stable(wr_addr) && $stable(wr_data)));

   // R3
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && $past(wr_rsp)));

   // R12
   es_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (es_vld && !es_clr) |=> es_vld);

   // R10
   ecx_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (es_ecx || es_sbe || es_dbe) |-> es_vld);

   // R11
   irq_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err_irq |-> es_vld);

endmodule

bind dma_seq_abort dma_seq_abort_chk #(.AW(AW), .DW(DW)) chk_i (
   .clk     (clk),
   .rst_n   (rst_n),
   .rd_req  (rd_req),
   .rd_rsp  (rd_rsp),
   .rd_addr (rd_addr),
   .wr_req  (wr_req),
   .wr_rsp  (wr_rsp),
   .wr_addr (wr_addr),
   .wr_data (wr_data),
   .busy    (busy),
   .done    (done),
   .es_vld  (es_vld),
   .es_ecx  (es_ecx),
   .es_sbe  (es_sbe),
   .es_dbe  (es_dbe),
   .es_clr  (es_clr),
   .err_irq (err_irq)
);

// File: tb/dma_seq_abort_tb_top.sv
module dma_seq_abort_tb_top;

   localparam int AW = 32, DW = 32, OW = 16, IW = 16, BW = 8, CHW = 4, CH_ID = 5;

   logic clk = 1'b0, rst_n = 1'b0;
   logic start = 0, cancel = 0, err_cancel = 0, err_irq_en = 0, es_clr = 0;
   logic [AW-1:0] cfg_src = '0, cfg_dst = '0;
   logic [OW-1:0] cfg_soff = '0, cfg_doff = '0;
   logic [BW-1:0] cfg_nbeats = '0;
   logic [IW-1:0] cfg_iter = '0;
   logic rd_rsp = 0, rd_err = 0, wr_rsp = 0, wr_err = 0;
   logic [DW-1:0] rd_data = '0;
   logic rd_req, wr_req, busy, done, es_sbe, es_dbe, es_ecx, es_vld, err_irq;
   logic [AW-1:0] rd_addr, wr_addr, cur_src, cur_dst;
   logic [DW-1:0] wr_data;
   logic [IW-1:0] cur_iter;
   logic [CHW-1:0] es_chn;

   int n_chk = 0, n_fail = 0, done_cnt = 0;

   always #10 clk = ~clk;

   dma_seq_abort #(.AW(AW), .DW(DW), .OW(OW), .IW(IW), .BW(BW), .CHW(CHW), .CH_ID(CH_ID)) dut_i (
      .clk(clk), .rst_n(rst_n), .start(start), .cfg_src(cfg_src), .cfg_dst(cfg_dst),
      .cfg_soff(cfg_soff), .cfg_doff(cfg_doff), .cfg_nbeats(cfg_nbeats), .cfg_iter(cfg_iter),
      .cancel(cancel), .err_cancel(err_cancel), .rd_req(rd_req), .rd_addr(rd_addr),
      .rd_rsp(rd_rsp), .rd_data(rd_data), .rd_err(rd_err), .wr_req(wr_req),
      .wr_addr(wr_addr), .wr_data(wr_data), .wr_rsp(wr_rsp), .wr_err(wr_err),
      .busy(busy), .done(done), .cur_src(cur_src), .cur_dst(cur_dst), .cur_iter(cur_iter),
      .err_irq_en(err_irq_en), .es_clr(es_clr), .es_chn(es_chn), .es_sbe(es_sbe),
      .es_dbe(es_dbe), .es_ecx(es_ecx), .es_vld(es_vld), .err_irq(err_irq));

   always @(negedge clk) if (done) done_cnt++;

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not finish act=%0d exp=%0d", 1, 0);
      summary();
   end

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   function automatic logic [DW-1:0] mem_val(input logic [AW-1:0] a);
      return a ^ 32'h5A5A_1234;
   endfunction

   task automatic wait_rd(output bit seen);
      seen = 0;
      for (int i = 0; i < 200; i++) begin
         if (rd_req) begin seen = 1; break; end
         @(negedge clk);
      end
   endtask

   task automatic wait_wr(output bit seen);
      seen = 0;
      for (int i = 0; i < 200; i++) begin
         if (wr_req) begin seen = 1; break; end
         @(negedge clk);
      end
   endtask

   task automatic rsp_rd(input logic [DW-1:0] dat, input bit err);
      repeat ($urandom_range(0, 2)) @(negedge clk);
      rd_rsp = 1; rd_err = err; rd_data = dat;
      @(negedge clk);
      rd_rsp = 0; rd_err = 0;
   endtask

   task automatic rsp_wr(input bit err);
      repeat ($urandom_range(0, 2)) @(negedge clk);
      wr_rsp = 1; wr_err = err;
      @(negedge clk);
      wr_rsp = 0; wr_err = 0;
   endtask

   // event: 0 none, 1 read error, 2 write error, 3 cancel, 4 error cancel
   task automatic run_job(input logic [31:0] s, input logic [31:0] d, input int so, input int dof,
                          input int nb, input int it, input int ev, input int ev_seq, input bit irq_en);
      logic [31:0] es_ = s, ed = d;
      int eit = it, total = nb * it, dbase;
      bit stopped = 0, exp_done = 0, x_sbe = 0, x_dbe = 0, x_ecx = 0, seen;
      @(negedge clk);
      cfg_src = s; cfg_dst = d; cfg_soff = OW'(so); cfg_doff = OW'(dof);
      cfg_nbeats = BW'(nb); cfg_iter = IW'(it); err_irq_en = irq_en;
      dbase = done_cnt;
      start = 1; @(negedge clk); start = 0;
      for (int k = 0; k < total && !stopped; k++) begin
         bit lastm = ((k % nb) == nb - 1);
         bit fin = (k == total - 1);
         bit rerr = (ev == 1 && k == ev_seq);
         bit werr = (ev == 2 && k == ev_seq);
         bit cx = ((ev == 3 || ev == 4) && k == ev_seq);
         logic [DW-1:0] dat;
         wait_rd(seen);
         chk(seen, "R2 read request issued", 32'(seen), 1);
         if (!seen) begin stopped = 1; break; end
         chk(rd_addr == es_, "R2 read address", rd_addr, es_);
         if (cx) begin
            if (ev == 4) err_cancel = 1; else cancel = 1;
            @(negedge clk);
            cancel = 0; err_cancel = 0;
         end
         dat = rerr ? (32'hBAD0_0000 | 32'(k)) : mem_val(es_);
         rsp_rd(dat, rerr);
         if (!rerr) es_ = es_ + 32'(so);
         wait_wr(seen);
         chk(seen, "R2 write request issued", 32'(seen), 1);
         if (!seen) begin stopped = 1; break; end
         chk(wr_addr == ed, rerr ? "R5 write address after read error" : "R2 write address", wr_addr, ed);
         chk(wr_data == dat, rerr ? "R5 write data from errored read" : "R2 write data", wr_data, dat);
         rsp_wr(werr);
         if (rerr) begin
            x_sbe = 1; stopped = 1;
         end else if (werr) begin
            x_dbe = 1; stopped = 1;
            if (!fin) begin
               wait_rd(seen);
               chk(seen, "R6 trailing read after write error", 32'(seen), 1);
               chk(rd_addr == es_, "R6 trailing read address", rd_addr, es_);
               rsp_rd(mem_val(es_), 0);
            end
         end else begin
            ed = ed + 32'(dof);
            if (lastm) eit--;
            if (fin) exp_done = 1;
            else if (cx && !lastm) begin
               stopped = 1;
               if (ev == 4) x_ecx = 1;
            end
         end
      end
      // stopped channel issues nothing further
      for (int i = 0; i < 4; i++) begin
         chk(!rd_req && !wr_req, "R7/R8 no access after stop", {30'd0, rd_req, wr_req}, 0);
         @(negedge clk);
      end
      chk(!busy, "R3 busy low after job", 32'(busy), 0);
      chk(cur_src == es_, "R5/R6/R8 descriptor source", cur_src, es_);
      chk(cur_dst == ed, "R5/R6/R8 descriptor destination", cur_dst, ed);
      chk(cur_iter == IW'(eit), "R2/R3 descriptor iteration", 32'(cur_iter), 32'(eit));
      chk((done_cnt - dbase) == (exp_done ? 1 : 0), "R3/R9 done pulse count",
          32'(done_cnt - dbase), exp_done ? 1 : 0);
      chk(es_sbe == x_sbe, "R5 source error flag", 32'(es_sbe), 32'(x_sbe));
      chk(es_dbe == x_dbe, "R6 destination error flag", 32'(es_dbe), 32'(x_dbe));
      chk(es_ecx == x_ecx, "R10 error cancel flag", 32'(es_ecx), 32'(x_ecx));
      chk(es_vld == (x_sbe | x_dbe | x_ecx), "R12 valid flag held", 32'(es_vld), 32'(x_sbe | x_dbe | x_ecx));
      if (es_vld) chk(es_chn == CHW'(CH_ID), "R10 channel number", 32'(es_chn), CH_ID);
      chk(err_irq == (es_vld & irq_en), "R11 interrupt", 32'(err_irq), 32'(es_vld & irq_en));
      es_clr = 1; @(negedge clk); es_clr = 0;
      chk(!es_vld && !es_sbe && !es_dbe && !es_ecx && !err_irq, "R12 clear strobe",
          {27'd0, es_vld, es_sbe, es_dbe, es_ecx, err_irq}, 0);
   endtask

   initial begin
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(!busy && !rd_req && !wr_req && !done, "R1 idle after reset",
          {28'd0, busy, rd_req, wr_req, done}, 0);
      chk(!es_vld && !es_sbe && !es_dbe && !es_ecx && !err_irq, "R1 error status after reset",
          {27'd0, es_vld, es_sbe, es_dbe, es_ecx, err_irq}, 0);
      rst_n = 1;
      @(negedge clk);
      run_job(32'h1000, 32'h8000, 4, 4, 2, 2, 0, 0, 0);        // R2 R3
      run_job(32'h2000, 32'h9000, -8, -4, 3, 1, 0, 0, 1);      // R2 negative offsets
      run_job(32'h3000, 32'hA000, 4, 8, 2, 2, 1, 1, 1);        // R5 R11
      run_job(32'h3100, 32'hA100, 4, 4, 2, 2, 1, 3, 0);        // R5 last read
      run_job(32'h4000, 32'hB000, 4, 4, 3, 2, 2, 1, 0);        // R6 R11 irq off
      run_job(32'h4100, 32'hB100, 4, 4, 2, 2, 2, 1, 1);        // R6 at minor end
      run_job(32'h5000, 32'hC000, 4, 4, 2, 2, 2, 3, 1);        // R7
      run_job(32'h6000, 32'hD000, 4, 4, 3, 2, 3, 0, 1);        // R8
      run_job(32'h6100, 32'hD100, 4, 4, 3, 2, 3, 2, 1);        // R9 cancel discarded
      run_job(32'h7000, 32'hE000, 2, 2, 3, 1, 4, 1, 1);        // R10
      run_job(32'h7100, 32'hE100, 2, 2, 3, 1, 4, 2, 1);        // R9 error cancel discarded
      run_job(32'h7200, 32'hE200, 2, 2, 1, 3, 4, 1, 1);        // R9 single-beat loops
      for (int j = 0; j < 40; j++) begin
         int nb = $urandom_range(1, 4);
         int it = $urandom_range(1, 3);
         int ev = $urandom_range(0, 4);
         int so = $urandom_range(0, 64) - 32;
         int dof = $urandom_range(0, 64) - 32;
         run_job({$urandom_range(1, 255), 12'h000}, {$urandom_range(256, 511), 12'h000},
                 so, dof, nb, it, ev, $urandom_range(0, nb * it - 1), 1'($urandom_range(0, 1)));
      end
      summary();
   end

endmodule